// File: doc/BRIEF.md
# Interleaved Dual-ADC Sample Combiner

Two converters digitise the same analog input on sampling clocks that are inverted relative to each other, so each delivers 16-bit samples at 250 MSa/s. Their samples alternate in time: one converter takes its sample half a sample clock before the other. This block reassembles the two 250 MSa/s lanes into one time-ordered stream that is equivalent to 500 MSa/s. It also lowers the rate: four consecutive samples of each lane go into one 64-bit lane word, and the two lane words are interleaved into a single wide output word that appears once every four input cycles.

The inputs are single-ended buses aligned to the block clock, and one sample of each lane arrives per clock while `in_valid` is high. A two-bit slot counter, cleared by a synchronous reset, selects where each sample lands. A configuration input swaps the roles of the two lanes for the case where the inputs arrive with the phase order reversed. An acquisition with two channels uses one instance per channel.

Top module: `ilv_combiner`

## Requirements
- R1: One cycle after a clock edge with `rst` high, `out_valid` is 0 and `out_word` is all zeros. Reset takes priority over a word completing in the same cycle.
- R2: `out_valid` is high for exactly one cycle, in the cycle after the edge that accepts the fourth sample pair of a run of consecutive `in_valid` cycles that starts at slot 0.
- R3: With `swap_lanes` low, `lane_a` is the earlier-phase lane. `out_word` holds eight 16-bit samples, with sample field k at bits [16k+15:16k] and field 0 in the least significant bits. Fields 0 to 7 hold A0, B0, A1, B1, A2, B2, A3, B3, where Ai and Bi are the i-th accepted samples of the run.
- R4: With `swap_lanes` high in the cycle a sample pair is accepted, `lane_b` supplies the A sample of that pair and `lane_a` supplies the B sample. The setting is sampled separately for each pair.
- R5: A cycle with `in_valid` low discards any partly filled word. The next accepted pair goes to slot 0, and no `out_valid` follows the gap cycle.
- R6: While `out_valid` is low, `out_word` keeps the last word that was delivered, or zero after reset.
- R7: `out_valid` is never high in two consecutive cycles.
- R8: A reset in the middle of a word discards the partial samples. After reset, packing starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, one sample pair per cycle |
| rst | input | 1 | Synchronous reset, active high |
| swap_lanes | input | 1 | 1 = `lane_b` is the earlier-phase lane |
| in_valid | input | 1 | A sample pair is present this cycle |
| lane_a | input | 16 | Sample from the first converter |
| lane_b | input | 16 | Sample from the second converter |
| out_valid | output | 1 | One-cycle strobe for a completed word |
| out_word | output | 128 | Eight time-ordered samples, earliest in the LSBs |

## Verification
Reset and word completion can fall in the same cycle: the bench holds `in_valid` high while it raises `rst` on the edge that would fill slot 3, and expects no strobe and a cleared word. The bench also raises reset at every other slot position, and opens an `in_valid` gap at every slot position, including the final one. A reference model in the bench predicts each strobe and each word field arithmetically. For the lane-swap setting, the bench toggles it within a word, so that single pairs of the assembled word come out with A and B exchanged.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   localparam int unsigned DEF_SAMPLE_W     = 16;
   localparam int unsigned DEF_WORD_SAMPLES = 4;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ilv_lane_route.sv
module ilv_lane_route #(
   parameter int unsigned SAMPLE_W = ilv_pkg::DEF_SAMPLE_W
) (
   input  logic                swap,
   input  logic [SAMPLE_W-1:0] in_a,
   input  logic [SAMPLE_W-1:0] in_b,
   output logic [SAMPLE_W-1:0] early,
   output logic [SAMPLE_W-1:0] late
);
   always_comb begin
      if (swap) begin
         early = in_b;
         late  = in_a;
      end else begin
         early = in_a;
         late  = in_b;
      end
   end
endmodule

// File: rtl/ilv_lane_packer.sv
module ilv_lane_packer #(
   parameter int unsigned SAMPLE_W     = ilv_pkg::DEF_SAMPLE_W,
   parameter int unsigned WORD_SAMPLES = ilv_pkg::DEF_WORD_SAMPLES,
   localparam int unsigned SLOT_W      = $clog2(WORD_SAMPLES),
   localparam int unsigned LANE_W      = SAMPLE_W * WORD_SAMPLES
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [SLOT_W-1:0]   slot,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [LANE_W-1:0]   packed_word
);
   // Slots 0..N-2 are held; the last slot comes straight from the input.
   for (genvar i = 0; i < WORD_SAMPLES - 1; i++) begin : g_slot
      logic [SAMPLE_W-1:0] held_q;
      always_ff @(posedge clk) begin
         if (rst)
            held_q <= '0;
         else if (load && (slot == SLOT_W'(i)))
            held_q <= sample;
      end
      assign packed_word[i*SAMPLE_W +: SAMPLE_W] = held_q;
   end
   assign packed_word[(WORD_SAMPLES-1)*SAMPLE_W +: SAMPLE_W] = sample;
endmodule

// File: rtl/ilv_interleave.sv
module ilv_interleave #(
   parameter int unsigned SAMPLE_W     = ilv_pkg::DEF_SAMPLE_W,
   parameter int unsigned WORD_SAMPLES = ilv_pkg::DEF_WORD_SAMPLES,
   localparam int unsigned LANE_W      = SAMPLE_W * WORD_SAMPLES,
   localparam int unsigned OUT_W       = 2 * LANE_W
) (
   input  logic [LANE_W-1:0] early_word,
   input  logic [LANE_W-1:0] late_word,
   output logic [OUT_W-1:0]  merged
);
   for (genvar i = 0; i < WORD_SAMPLES; i++) begin : g_pair
      assign merged[(2*i)*SAMPLE_W   +: SAMPLE_W] = early_word[i*SAMPLE_W +: SAMPLE_W];
      assign merged[(2*i+1)*SAMPLE_W +: SAMPLE_W] = late_word[i*SAMPLE_W +: SAMPLE_W];
   end
endmodule

// File: rtl/ilv_combiner.sv
module ilv_combiner #(
   parameter int unsigned SAMPLE_W     = ilv_pkg::DEF_SAMPLE_W,
   parameter int unsigned WORD_SAMPLES = ilv_pkg::DEF_WORD_SAMPLES,
   localparam int unsigned SLOT_W      = $clog2(WORD_SAMPLES),
   localparam int unsigned LANE_W      = SAMPLE_W * WORD_SAMPLES,
   localparam int unsigned OUT_W       = 2 * LANE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                swap_lanes,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] lane_a,
   input  logic [SAMPLE_W-1:0] lane_b,
   output logic                out_valid,
   output logic [OUT_W-1:0]    out_word
);
   if (WORD_SAMPLES < 2 || !ilv_pkg::is_pow2(WORD_SAMPLES)) begin : g_bad_depth
      $error("WORD_SAMPLES must be a power of two and at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("SAMPLE_W must be at least 1");
   end

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_SAMPLES - 1);

   logic [SLOT_W-1:0]   slot_q;
   logic [SAMPLE_W-1:0] early_s, late_s;
   logic [LANE_W-1:0]   early_word, late_word;
   logic [OUT_W-1:0]    merged;
   logic                word_done;

   assign word_done = in_valid && (slot_q == LAST_SLOT);

   // The slot counter wraps naturally because the depth is a power of two.
   always_ff @(posedge clk) begin
      if (rst || !in_valid)
         slot_q <= '0;
      else
         slot_q <= slot_q + 1'b1;
   end

   ilv_lane_route #(.SAMPLE_W(SAMPLE_W)) u_route (
      .swap  (swap_lanes),
      .in_a  (lane_a),
      .in_b  (lane_b),
      .early (early_s),
      .late  (late_s)
   );

   ilv_lane_packer #(.SAMPLE_W(SAMPLE_W), .WORD_SAMPLES(WORD_SAMPLES)) u_pack_early (
      .clk         (clk),
      .rst         (rst),
      .load        (in_valid),
      .slot        (slot_q),
      .sample      (early_s),
      .packed_word (early_word)
   );

   ilv_lane_packer #(.SAMPLE_W(SAMPLE_W), .WORD_SAMPLES(WORD_SAMPLES)) u_pack_late (
      .clk         (clk),
      .rst         (rst),
      .load        (in_valid),
      .slot        (slot_q),
      .sample      (late_s),
      .packed_word (late_word)
   );

   ilv_interleave #(.SAMPLE_W(SAMPLE_W), .WORD_SAMPLES(WORD_SAMPLES)) u_merge (
      .early_word (early_word),
      .late_word  (late_word),
      .merged     (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= word_done;
         if (word_done)
            out_word <= merged;
      end
   end
endmodule

// File: rtl/ilv_combiner_chk.sv
module ilv_combiner_chk #(
   parameter int unsigned SAMPLE_W     = ilv_pkg::DEF_SAMPLE_W,
   parameter int unsigned WORD_SAMPLES = ilv_pkg::DEF_WORD_SAMPLES,
   localparam int unsigned OUT_W       = 2 * SAMPLE_W * WORD_SAMPLES
) (
   input logic                clk,
   input logic                rst,
   input logic                swap_lanes,
   input logic                in_valid,
   input logic [SAMPLE_W-1:0] lane_a,
   input logic [SAMPLE_W-1:0] lane_b,
   input logic                out_valid,
   input logic [OUT_W-1:0]    out_word
);
   // R1
   rst_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_word == '0));

   // R2
   strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   // R3
   last_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(swap_lanes)) |->
         out_word[OUT_W-1 -: 2*SAMPLE_W] == {$past(lane_b), $past(lane_a)});

   // R4
   last_pair_swap_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(swap_lanes)) |->
         out_word[OUT_W-1 -: 2*SAMPLE_W] == {$past(lane_a), $past(lane_b)});

   // R5
   gap_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R6
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && !$past(rst)) |-> $stable(out_word));

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
endmodule

bind ilv_combiner ilv_combiner_chk #(
   .SAMPLE_W     (SAMPLE_W),
   .WORD_SAMPLES (WORD_SAMPLES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .swap_lanes (swap_lanes),
   .in_valid   (in_valid),
   .lane_a     (lane_a),
   .lane_b     (lane_b),
   .out_valid  (out_valid),
   .out_word   (out_word)
);

// File: tb/sim_ilv_combiner.sv
module sim_ilv_combiner;
   localparam int W = 16;
   localparam int N = 4;
   localparam int OW = 2 * W * N;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          swap_lanes = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  lane_a = '0;
   logic [W-1:0]  lane_b = '0;
   logic          out_valid;
   logic [OW-1:0] out_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int            run = 0;
   int            seq = 0;
   logic [W-1:0]  ea [N];
   logic [W-1:0]  eb [N];
   logic          exp_v = 1'b0;
   logic [OW-1:0] exp_w = '0;

   always #2 clk = ~clk;

   ilv_combiner #(.SAMPLE_W(W), .WORD_SAMPLES(N)) u0 (
      .clk(clk), .rst(rst), .swap_lanes(swap_lanes), .in_valid(in_valid),
      .lane_a(lane_a), .lane_b(lane_b), .out_valid(out_valid), .out_word(out_word)
   );

   task automatic check(input string tag);
      checks++;
      if (out_valid !== exp_v || out_word !== exp_w) begin
         fails++;
         $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                  tag, out_valid, out_word, exp_v, exp_w);
      end
   endtask

   // Drive one cycle, update the reference model, then sample after the edge.
   task automatic step(input bit r, input bit v, input bit sw, input string tag);
      logic [W-1:0] a, b;
      a = W'(16'hA000 + seq * 37);
      b = W'(16'h5000 + seq * 91);
      seq++;
      rst = r; in_valid = v; swap_lanes = sw; lane_a = a; lane_b = b;
      @(posedge clk);
      #1;
      if (r) begin
         run = 0; exp_v = 1'b0; exp_w = '0;
      end else if (v) begin
         ea[run] = sw ? b : a;
         eb[run] = sw ? a : b;
         if (run == N - 1) begin
            exp_v = 1'b1;
            for (int k = 0; k < N; k++) begin
               exp_w[(2*k)*W +: W]   = ea[k];
               exp_w[(2*k+1)*W +: W] = eb[k];
            end
            run = 0;
         end else begin
            exp_v = 1'b0;
            run++;
         end
      end else begin
         run = 0; exp_v = 1'b0;
      end
      check(tag);
   endtask

   initial begin
      // R1: reset state
      step(1'b1, 1'b0, 1'b0, "R1 reset");
      step(1'b1, 1'b1, 1'b0, "R1 reset");
      // R2 R3 R6 R7: continuous words, no swap
      for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, "R3 ordered words");
      // R4: swapped lanes, then swap toggled inside words
      for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, "R4 swapped");
      for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'(i % 3 == 1), "R4 toggled swap");
      // R5: gap after every slot position, with and without swap
      for (int sw = 0; sw < 2; sw++) begin
         for (int g = 0; g <= N; g++) begin
            for (int i = 0; i < g; i++) step(1'b0, 1'b1, 1'(sw), "R5 before gap");
            step(1'b0, 1'b0, 1'(sw), "R5 gap");
            step(1'b0, 1'b0, 1'(sw), "R6 idle hold");
            for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'(sw), "R5 after gap");
         end
      end
      // R8 R1: reset at every slot, including the cycle that fills the last slot
      for (int k = 0; k < N; k++) begin
         for (int i = 0; i < k; i++) step(1'b0, 1'b1, 1'b0, "R8 partial");
         step(1'b1, 1'b1, 1'b0, "R1 reset wins over completion");
         for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, "R8 after reset");
         step(1'b0, 1'b0, 1'b0, "R7 no repeat");
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule